// File: doc/BRIEF.md
# Bus-to-SRAM Test Bridge

This block is a slave on a Wishbone B4 classic bus. It gives a host read and write access to a set of synchronous single-cycle SRAM macros through one memory map. Bits [19:16] of the bus address pick one of 16 windows. Windows 0 to `NUM_MEM-1` each hold one memory. The remaining windows are unmapped.

For a mapped window, the bridge pulls that memory's active-low chip select low during the request cycle. It drives a shared active-low write enable and passes the bus data, the byte selects and the low address bits straight through. In the next cycle it raises the acknowledge. On a read, that acknowledge cycle also carries the word the memory returned.

An unmapped window drives no chip select. It is still acknowledged, and it returns zero. The bridge takes no new request while its acknowledge is high, so a master that holds its strobe for one extra cycle does not start a second access.

Top module: `wb_sram_bridge`

## Requirements
- R1: While cyc and stb are both high, ack is low and address bits [19:16] hold a value i below NUM_MEM, exactly bit i of `mem_csn` is low and every other bit is high.
- R2: When either cyc or stb is low, every bit of `mem_csn` is high and `mem_wen` is high.
- R3: In a request cycle to a mapped window, `mem_wen` is 0 when `bus_we` is 1 and 1 otherwise. `mem_wen` is 1 for an unmapped window.
- R4: `mem_wdata` equals `bus_wdat`, and `mem_addr` equals `bus_adr[AW-1:0]`. Address bits [31:20] and [15:AW] do not affect which memory is selected.
- R5: `mem_wmask` bit b equals `bus_sel` bit b, and byte lane b is data bits [8b+7:8b]. A write changes only the bytes whose mask bit is 1.
- R6: `bus_ack` is high for exactly the one cycle after each accepted request. No chip select is low while `bus_ack` is high.
- R7: In the acknowledge cycle of a read from window i, `bus_rdat` equals the word that memory i holds at the requested address.
- R8: A request to a window at or above NUM_MEM is acknowledged and returns zero. It selects no memory, so a write there leaves every memory unchanged.
- R9: While reset is asserted, and for the two cycles of its synchronous release, `bus_ack` is low and no chip select is low, even with a request on the bus.
- R10: `bus_rdat` is zero in every cycle where `bus_ack` is low, and in the acknowledge cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Strobe for this slave |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 32 | Byte address; [19:16] is the window, [AW-1:0] is the word address |
| bus_sel | input | 4 | Byte selects |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Acknowledge |
| mem_csn | output | NUM_MEM | Active-low chip select, one bit per memory |
| mem_wen | output | 1 | Shared active-low write enable |
| mem_wmask | output | 4 | Byte write mask |
| mem_addr | output | AW | Word address to the memories |
| mem_wdata | output | 32 | Write data to the memories |
| mem_rdata | input | NUM_MEM*32 | Read data from each memory; memory i drives bits [32i+31:32i] |

## Verification
Two cases are hard to reach from the ports.

The first is a write into an unmapped window that reuses the low address bits of a word already stored in a real memory. Its harm shows up only as corruption found on a later read. The directed stimulus stores a known word, writes to window 15 with the same low address and then reads the word back.

The second is a strobe held into the acknowledge cycle. Every access keeps stb high until the next falling edge after the acknowledge. The bench checks that the chip selects stay high in that cycle.

Random traffic, with about one request in five going to an unmapped window, mixes partial byte masks with reuse of a small address range. This lets reads meet words assembled from several partial writes.

// File: rtl/wbsb_pkg.sv
`timescale 1ns/1ps
package wbsb_pkg;
  localparam int DW      = 32;
  localparam int BW      = DW / 8;
  localparam int ADR_W   = 32;
  localparam int WIN_LSB = 16;
  localparam int WIN_W   = 4;
  localparam int NWIN    = 1 << WIN_W;

  typedef logic [WIN_W-1:0] win_t;

  // captured description of the request being answered
  typedef struct packed {
    logic mapped;
    logic rd;
    win_t win;
  } rsp_t;
endpackage

// File: rtl/wbsb_rst_sync.sv
`timescale 1ns/1ps
module wbsb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wbsb_decode.sv
`timescale 1ns/1ps
module wbsb_decode
  import wbsb_pkg::*;
#(
  parameter int NUM_MEM = 6
) (
  input  logic               live,
  input  logic               cyc,
  input  logic               stb,
  input  logic               busy,
  input  logic               we,
  input  logic [ADR_W-1:0]   adr,
  output logic [NUM_MEM-1:0] csn,
  output logic               wen,
  output logic               accept,
  output win_t               win,
  output logic               mapped
);
  logic               req;
  logic [NUM_MEM-1:0] hit;

  always_comb begin
    req    = live & cyc & stb & ~busy;
    win    = adr[WIN_LSB +: WIN_W];
    mapped = (32'(win) < NUM_MEM);
    accept = req;
    wen    = ~(req & mapped & we);
  end

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_sel
    always_comb begin
      hit[i] = req & (win == WIN_W'(i));
    end
  end

  assign csn = ~hit;
endmodule

// File: rtl/wbsb_resp.sv
`timescale 1ns/1ps
module wbsb_resp
  import wbsb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic we,
  input  logic mapped,
  input  win_t win,
  output logic ack,
  output rsp_t rsp
);
  logic ack_d;
  rsp_t rsp_d;
  rsp_t rsp_q;
  logic ack_q;

  always_comb begin
    ack_d = accept;
    rsp_d = rsp_q;
    if (accept) begin
      rsp_d.mapped = mapped;
      rsp_d.rd     = ~we;
      rsp_d.win    = win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      rsp_q <= '0;
    end else begin
      ack_q <= ack_d;
      rsp_q <= rsp_d;
    end
  end

  assign ack = ack_q;
  assign rsp = rsp_q;
endmodule

// File: rtl/wbsb_rmux.sv
`timescale 1ns/1ps
module wbsb_rmux
  import wbsb_pkg::*;
#(
  parameter int NUM_MEM = 6
) (
  input  logic                  ack,
  input  rsp_t                  rsp,
  input  logic [NUM_MEM*DW-1:0] mem_rdata,
  output logic [DW-1:0]         rdat
);
  logic [DW-1:0] lane [NUM_MEM];

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_lane
    always_comb begin
      if (rsp.win == WIN_W'(i)) lane[i] = mem_rdata[i*DW +: DW];
      else                      lane[i] = '0;
    end
  end

  always_comb begin
    rdat = '0;
    if (ack && rsp.mapped && rsp.rd) begin
      for (int i = 0; i < NUM_MEM; i++) rdat = rdat | lane[i];
    end
  end
endmodule

// File: rtl/wb_sram_bridge.sv
`timescale 1ns/1ps
module wb_sram_bridge
  import wbsb_pkg::*;
#(
  parameter int NUM_MEM = 6,
  parameter int AW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_cyc,
  input  logic                  bus_stb,
  input  logic                  bus_we,
  input  logic [31:0]           bus_adr,
  input  logic [3:0]            bus_sel,
  input  logic [31:0]           bus_wdat,
  output logic [31:0]           bus_rdat,
  output logic                  bus_ack,
  output logic [NUM_MEM-1:0]    mem_csn,
  output logic                  mem_wen,
  output logic [3:0]            mem_wmask,
  output logic [AW-1:0]         mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic [NUM_MEM*32-1:0] mem_rdata
);
  logic rst_sync_n;
  logic accept;
  logic mapped;
  win_t win;
  rsp_t rsp;

  wbsb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wbsb_decode #(.NUM_MEM(NUM_MEM)) u_dec (
    .live   (rst_sync_n),
    .cyc    (bus_cyc),
    .stb    (bus_stb),
    .busy   (bus_ack),
    .we     (bus_we),
    .adr    (bus_adr),
    .csn    (mem_csn),
    .wen    (mem_wen),
    .accept (accept),
    .win    (win),
    .mapped (mapped)
  );

  wbsb_resp u_rsp (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .accept (accept),
    .we     (bus_we),
    .mapped (mapped),
    .win    (win),
    .ack    (bus_ack),
    .rsp    (rsp)
  );

  wbsb_rmux #(.NUM_MEM(NUM_MEM)) u_mux (
    .ack       (bus_ack),
    .rsp       (rsp),
    .mem_rdata (mem_rdata),
    .rdat      (bus_rdat)
  );

  assign mem_addr  = bus_adr[AW-1:0];
  assign mem_wdata = bus_wdat;
  assign mem_wmask = bus_sel;
endmodule

// File: rtl/wbsb_chk.sv
`timescale 1ns/1ps
module wbsb_chk #(
  parameter int NUM_MEM = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_cyc,
  input logic               bus_stb,
  input logic               bus_we,
  input logic [31:0]        bus_adr,
  input logic               bus_ack,
  input logic [31:0]        bus_rdat,
  input logic [NUM_MEM-1:0] mem_csn,
  input logic               mem_wen
);
  logic req;
  assign req = bus_cyc && bus_stb && !bus_ack;

  p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_csn));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cyc && bus_stb) |-> (&mem_csn && mem_wen));

  p_read_no_wen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !bus_we) |-> mem_wen);

  p_ack_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> bus_ack);

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  p_no_sel_in_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> &mem_csn);

  p_unmapped_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (32'(bus_adr[19:16]) >= NUM_MEM)) |-> &mem_csn);

  p_rdat_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (bus_rdat == '0));

  p_write_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && bus_we) |=> (bus_rdat == '0));
endmodule

bind wb_sram_bridge wbsb_chk #(.NUM_MEM(NUM_MEM)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_cyc  (bus_cyc),
  .bus_stb  (bus_stb),
  .bus_we   (bus_we),
  .bus_adr  (bus_adr),
  .bus_ack  (bus_ack),
  .bus_rdat (bus_rdat),
  .mem_csn  (mem_csn),
  .mem_wen  (mem_wen)
);

// File: tb/wb_sram_bridge_bench.sv
`timescale 1ns/1ps
module wb_sram_bridge_bench;
  localparam int NUM_MEM = 6;
  localparam int AW      = 8;
  localparam int DEPTH   = 1 << AW;

  logic                  clk;
  logic                  rst_n;
  logic                  bus_cyc, bus_stb, bus_we;
  logic [31:0]           bus_adr;
  logic [3:0]            bus_sel;
  logic [31:0]           bus_wdat;
  logic [31:0]           bus_rdat;
  logic                  bus_ack;
  logic [NUM_MEM-1:0]    mem_csn;
  logic                  mem_wen;
  logic [3:0]            mem_wmask;
  logic [AW-1:0]         mem_addr;
  logic [31:0]           mem_wdata;
  logic [NUM_MEM*32-1:0] mem_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  wb_sram_bridge #(.NUM_MEM(NUM_MEM), .AW(AW)) u_wb_sram_bridge (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural synchronous memories
  logic [31:0] sram [NUM_MEM][DEPTH];
  logic [31:0] sram_q [NUM_MEM];
  always @(posedge clk) begin
    for (int i = 0; i < NUM_MEM; i++) begin
      if (!mem_csn[i]) begin
        if (!mem_wen) begin
          for (int b = 0; b < 4; b++)
            if (mem_wmask[b]) sram[i][mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end else begin
          sram_q[i] <= sram[i][mem_addr];
        end
      end
    end
  end
  always_comb for (int i = 0; i < NUM_MEM; i++) mem_rdata[i*32 +: 32] = sram_q[i];

  // bench reference model
  logic [31:0] model [NUM_MEM][DEPTH];

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d, logic [3:0] s);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [NUM_MEM-1:0] exp_csn(int win);
    logic [NUM_MEM-1:0] c = '1;
    if (win < NUM_MEM) c[win] = 1'b0;
    return c;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(bit we, int win, int a, logic [31:0] d, logic [3:0] sel,
                        logic [11:0] hi);
    bit mapped = (win < NUM_MEM);
    logic [31:0] exp_rd;
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = we; bus_sel = sel; bus_wdat = d;
    bus_adr = {hi, 4'(win), 8'h00, 8'(a)};
    #1;
    check(mem_csn == exp_csn(win), mapped ? "R1 select" : "R8 no select",
          64'(mem_csn), 64'(exp_csn(win)));
    check(mem_wen == !(we && mapped), "R3 write enable", 64'(mem_wen), 64'(!(we && mapped)));
    check(mem_addr == AW'(a) && mem_wdata == d, "R4 addr/data",
          {mem_addr, mem_wdata}, {AW'(a), d});
    check(mem_wmask == sel, "R5 mask", 64'(mem_wmask), 64'(sel));
    exp_rd = (!we && mapped) ? model[win][a] : 32'h0;
    if (we && mapped) model[win][a] = merge(model[win][a], d, sel);
    @(negedge clk);
    check(bus_ack == 1'b1, "R6 ack", 64'(bus_ack), 64'd1);
    check(&mem_csn, "R6 no reissue", 64'(mem_csn), 64'(exp_csn(NUM_MEM)));
    check(bus_rdat == exp_rd, we ? "R10 write data zero" : (mapped ? "R7 read data" : "R8 zero data"),
          64'(bus_rdat), 64'(exp_rd));
    bus_cyc = 0; bus_stb = 0;
    @(negedge clk);
    check(bus_ack == 1'b0 && bus_rdat == 0, "R10 idle after ack", {bus_ack, bus_rdat}, 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    for (int i = 0; i < NUM_MEM; i++)
      for (int j = 0; j < DEPTH; j++) begin sram[i][j] = 0; model[i][j] = 0; end
    bus_cyc = 0; bus_stb = 0; bus_we = 0; bus_adr = 0; bus_sel = 0; bus_wdat = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_adr = 32'h0001_0000;
    #1;
    check(bus_ack == 0 && &mem_csn, "R9 reset quiet", {bus_ack, mem_csn}, 64'(exp_csn(NUM_MEM)));
    bus_cyc = 0; bus_stb = 0;
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 half requests
    bus_cyc = 1; bus_stb = 0; bus_we = 1; bus_adr = 32'h0002_0004; #1;
    check(&mem_csn && mem_wen, "R2 cyc only", {mem_csn, mem_wen}, 64'h7F);
    bus_cyc = 0; bus_stb = 1; #1;
    check(&mem_csn && mem_wen, "R2 stb only", {mem_csn, mem_wen}, 64'h7F);
    bus_stb = 0; bus_we = 0;
    @(negedge clk);
    check(bus_ack == 0, "R2 no ack", 64'(bus_ack), 64'd0);

    // directed corners
    access(1, 0, DEPTH-1, 32'hA5A5_1234, 4'hF, 12'h000);   // R4 top word
    access(0, 0, DEPTH-1, 0, 4'h0, 12'hFFF);               // R4 upper bits ignored
    access(1, 3, 7, 32'h1122_3344, 4'hF, 12'h000);
    access(1, 3, 7, 32'hFFFF_FFFF, 4'b0101, 12'h000);      // R5 partial
    access(0, 3, 7, 0, 4'h0, 12'h000);
    access(1, 0, 9, 32'hCAFE_0009, 4'hF, 12'h000);
    access(1, 15, 9, 32'hDEAD_BEEF, 4'hF, 12'h000);        // R8 unmapped write
    access(0, 15, 9, 0, 4'h0, 12'h000);                    // R8 zero read
    access(0, 0, 9, 0, 4'h0, 12'h000);                     // R8 nothing corrupted
    access(0, NUM_MEM-1, 9, 0, 4'h0, 12'h000);
    access(1, NUM_MEM, 9, 32'h0BAD_0BAD, 4'hF, 12'h000);   // R8 first unmapped

    // random traffic
    for (int k = 0; k < 400; k++) begin
      int w;
      w = ($urandom % 5 == 0) ? NUM_MEM + int'($urandom % (16 - NUM_MEM))
                              : int'($urandom % NUM_MEM);
      access(1'($urandom), w, int'($urandom % 16), $urandom, 4'($urandom),
             12'($urandom));
    end

    // final readback of random area (R7)
    for (int w = 0; w < NUM_MEM; w++)
      for (int a = 0; a < 16; a++) access(0, w, a, 0, 4'h0, 12'h000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule